// File: doc/BRIEF.md
# Vector Integer Multiply-Add Unit

This block executes the four single-width integer multiply-add vector operations on one packed vector register. A 32-bit instruction word and a start strobe arrive together with three vector operands (the second source vector, the first source vector, the current destination vector) and a scalar register value. The active element width, the vector length and a per-element mask vector arrive alongside them. One clock edge later the block presents the new destination vector and a valid flag for one cycle. An illegal flag is also shown when the instruction word is not one of the supported encodings.

The four operations differ in two ways. One is whether the old destination element is the addend or a multiplicand. The other is whether the product is added or subtracted. A vector-scalar form replaces every lane's first-source element with the scalar, cut down to the element width. Arithmetic wraps modulo the element width: no widening and no saturation. Lanes turned off by the mask keep their old value. Lanes at or beyond the vector length are written as zero.

Top module: `vmac_unit`

## Requirements
- R1: `res_valid_o` is high in exactly the cycle after a cycle with `start_i` high, and low otherwise. After reset, `res_valid_o`, `illegal_o` and `res_o` are all zero.
- R2: funct6 (instruction bits 31:26) = 101101 gives multiply-accumulate: new[i] = vs1[i]*vs2[i] + vd[i].
- R3: funct6 = 101111 gives negated multiply-subtract-accumulate: new[i] = vd[i] - vs1[i]*vs2[i].
- R4: funct6 = 101001 gives multiply-add: new[i] = vs1[i]*vd[i] + vs2[i].
- R5: funct6 = 101011 gives negated multiply-subtract: new[i] = vs2[i] - vs1[i]*vd[i].
- R6: funct3 (bits 14:12) = 010 selects the vector-vector form. 110 selects the vector-scalar form, in which the low element-width bits of `rs1_i` replace vs1[i] in every lane.
- R7: `sew_i` codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements. Element i occupies bits [i*EW +: EW] of each vector, and each result keeps only the low EW bits of the product-sum.
- R8: When instruction bit 25 is 0, an active element whose bit i of `mask_i` is 0 keeps its old vd value. When bit 25 is 1, the mask is ignored.
- R9: Every element with index >= `vl_i` is written as zero.
- R10: If bits 6:0 are not 1010111, or funct6 or funct3 is outside the values above, `illegal_o` is 1 with the result and `res_o` equals the old vd vector unchanged.
- R11: Without a start strobe, `res_o` and `illegal_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; all other inputs sampled in this cycle |
| insn_i | input | 32 | Instruction word |
| vs2_i | input | VLEN (128) | Second source vector |
| vs1_i | input | VLEN (128) | First source vector |
| rs1_i | input | XLEN (64) | Scalar operand for the vector-scalar form |
| vd_old_i | input | VLEN (128) | Current destination vector |
| sew_i | input | 2 | Element width code |
| vl_i | input | VL_W (5) | Vector length in elements |
| mask_i | input | VLEN/8 (16) | Mask bit per element index |
| res_valid_o | output | 1 | Result valid, one cycle after start |
| illegal_o | output | 1 | Instruction not supported |
| res_o | output | VLEN (128) | New destination vector |

## Verification
All results are due one clock edge after the start strobe: the result, the illegal flag and the valid pulse are registered together at the edge that samples `start_i`. The bench drives each operation on a falling edge and lowers the strobe on the next falling edge. It samples `res_o`, `illegal_o` and `res_valid_o` there, half a cycle after the capturing edge. It samples once more one falling edge later to see the valid pulse end and the result hold. Expected vectors come from a per-element model written from the requirements, plus a few hand-worked constants for wraparound and tail cases.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

  typedef enum logic [1:0] {
    OP_MACC  = 2'd0,
    OP_NMSAC = 2'd1,
    OP_MADD  = 2'd2,
    OP_NMSUB = 2'd3
  } vmac_op_e;

  localparam logic [6:0] OPC_VECTOR = 7'b1010111;
  localparam logic [5:0] F6_MACC    = 6'b101101;
  localparam logic [5:0] F6_NMSAC   = 6'b101111;
  localparam logic [5:0] F6_MADD    = 6'b101001;
  localparam logic [5:0] F6_NMSUB   = 6'b101011;
  localparam logic [2:0] F3_VV      = 3'b010;
  localparam logic [2:0] F3_VX      = 3'b110;

  localparam int NUM_WIDTHS = 4;

  typedef struct packed {
    vmac_op_e op;
    logic     scalar_src;
    logic     all_lanes;
    logic     legal;
  } vmac_ctl_t;

endpackage

// File: rtl/vmac_decode.sv
module vmac_decode
  import vmac_pkg::*;
(
  input  logic [31:0] insn_i,
  output vmac_ctl_t   ctl_o
);

  logic [5:0] funct6;
  logic [2:0] funct3;
  logic [6:0] opcode;
  logic       f6_ok;
  logic       f3_ok;
  vmac_op_e   op_sel;
  logic       unused_fields;

  assign funct6 = insn_i[31:26];
  assign funct3 = insn_i[14:12];
  assign opcode = insn_i[6:0];
  assign unused_fields = ^{insn_i[24:15], insn_i[11:7]};

  always_comb begin
    f6_ok  = 1'b1;
    op_sel = OP_MACC;
    unique case (funct6)
      F6_MACC:  op_sel = OP_MACC;
      F6_NMSAC: op_sel = OP_NMSAC;
      F6_MADD:  op_sel = OP_MADD;
      F6_NMSUB: op_sel = OP_NMSUB;
      default:  f6_ok  = 1'b0;
    endcase
  end

  assign f3_ok = (funct3 == F3_VV) || (funct3 == F3_VX);

  always_comb begin
    ctl_o.op         = op_sel;
    ctl_o.scalar_src = (funct3 == F3_VX);
    ctl_o.all_lanes  = insn_i[25];
    ctl_o.legal      = f6_ok && f3_ok && (opcode == OPC_VECTOR);
  end

endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
  import vmac_pkg::*;
#(
  parameter int EW = 8
) (
  input  vmac_op_e      op_i,
  input  logic [EW-1:0] src2_i,
  input  logic [EW-1:0] src1_i,
  input  logic [EW-1:0] dst_i,
  output logic [EW-1:0] res_o
);

  logic          dst_is_factor;
  logic          subtract;
  logic [EW-1:0] factor;
  logic [EW-1:0] addend;
  logic [EW-1:0] product;

  always_comb begin
    dst_is_factor = 1'b0;
    subtract      = 1'b0;
    unique case (op_i)
      OP_MACC:  begin dst_is_factor = 1'b0; subtract = 1'b0; end
      OP_NMSAC: begin dst_is_factor = 1'b0; subtract = 1'b1; end
      OP_MADD:  begin dst_is_factor = 1'b1; subtract = 1'b0; end
      OP_NMSUB: begin dst_is_factor = 1'b1; subtract = 1'b1; end
      default:  begin dst_is_factor = 1'b0; subtract = 1'b0; end
    endcase
  end

  always_comb begin
    factor  = dst_is_factor ? dst_i  : src2_i;
    addend  = dst_is_factor ? src2_i : dst_i;
    product = src1_i * factor;
    res_o   = subtract ? (addend - product) : (addend + product);
  end

endmodule

// File: rtl/vmac_slice.sv
module vmac_slice
  import vmac_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int XLEN  = 64,
  parameter int EW    = 8,
  parameter int MAXEL = VLEN / 8,
  parameter int VL_W  = $clog2(MAXEL) + 1
) (
  input  vmac_ctl_t        ctl_i,
  input  logic [VLEN-1:0]  vs2_i,
  input  logic [VLEN-1:0]  vs1_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [VLEN-1:0]  vd_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [MAXEL-1:0] mask_i,
  output logic [VLEN-1:0]  res_o
);

  localparam int NEL = VLEN / EW;

  logic [EW-1:0] scalar_el;
  logic          unused_bits;

  assign scalar_el   = rs1_i[EW-1:0];
  assign unused_bits = ^{rs1_i, mask_i, ctl_i.legal};

  for (genvar i = 0; i < NEL; i++) begin : g_el
    logic [EW-1:0] s1_el;
    logic [EW-1:0] lane_res;
    logic          active;
    logic          enabled;

    assign s1_el = ctl_i.scalar_src ? scalar_el : vs1_i[i*EW +: EW];

    vmac_lane #(.EW(EW)) u_lane (
      .op_i   (ctl_i.op),
      .src2_i (vs2_i[i*EW +: EW]),
      .src1_i (s1_el),
      .dst_i  (vd_i[i*EW +: EW]),
      .res_o  (lane_res)
    );

    assign active  = (VL_W'(i) < vl_i);
    assign enabled = ctl_i.all_lanes || mask_i[i];

    always_comb begin
      if (!active) begin
        res_o[i*EW +: EW] = '0;
      end else if (!enabled) begin
        res_o[i*EW +: EW] = vd_i[i*EW +: EW];
      end else begin
        res_o[i*EW +: EW] = lane_res;
      end
    end
  end

endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
  import vmac_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int XLEN  = 64,
  parameter int MAXEL = VLEN / 8,
  parameter int VL_W  = $clog2(MAXEL) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [31:0]      insn_i,
  input  logic [VLEN-1:0]  vs2_i,
  input  logic [VLEN-1:0]  vs1_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [VLEN-1:0]  vd_old_i,
  input  logic [1:0]       sew_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [MAXEL-1:0] mask_i,
  output logic             res_valid_o,
  output logic             illegal_o,
  output logic [VLEN-1:0]  res_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  // decode
  vmac_ctl_t ctl;

  vmac_decode u_dec (
    .insn_i (insn_i),
    .ctl_o  (ctl)
  );

  // one datapath slice per supported element width
  logic [VLEN-1:0] width_res [NUM_WIDTHS];

  for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
    vmac_slice #(
      .VLEN  (VLEN),
      .XLEN  (XLEN),
      .EW    (8 << w),
      .MAXEL (MAXEL),
      .VL_W  (VL_W)
    ) u_slice (
      .ctl_i  (ctl),
      .vs2_i  (vs2_i),
      .vs1_i  (vs1_i),
      .rs1_i  (rs1_i),
      .vd_i   (vd_old_i),
      .vl_i   (vl_i),
      .mask_i (mask_i),
      .res_o  (width_res[w])
    );
  end

  // next state
  logic            valid_d, valid_q;
  logic            ill_d,   ill_q;
  logic [VLEN-1:0] res_d,   res_q;
  logic            load_en;

  always_comb begin
    load_en = start_i;
    valid_d = start_i;
    ill_d   = !ctl.legal;
    res_d   = ctl.legal ? width_res[sew_i] : vd_old_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        ill_q <= ill_d;
        res_q <= res_d;
      end
    end
  end

  assign res_valid_o = valid_q;
  assign illegal_o   = ill_q;
  assign res_o       = res_q;

endmodule

// File: rtl/vmac_unit_chk.sv
module vmac_unit_chk #(
  parameter int VLEN  = 128,
  parameter int MAXEL = VLEN / 8,
  parameter int VL_W  = $clog2(MAXEL) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [31:0]      insn_i,
  input logic [VLEN-1:0]  vd_old_i,
  input logic [1:0]       sew_i,
  input logic [VL_W-1:0]  vl_i,
  input logic [MAXEL-1:0] mask_i,
  input logic             res_valid_o,
  input logic             illegal_o,
  input logic [VLEN-1:0]  res_o
);

  localparam int NBYTES = VLEN / 8;

  logic [VLEN-1:0]  vd_cap;
  logic [1:0]       sew_cap;
  logic [VL_W-1:0]  vl_cap;
  logic [MAXEL-1:0] mask_cap;
  logic             all_cap;
  logic [VLEN-1:0]  tail_bm;
  logic [VLEN-1:0]  keep_bm;
  logic             unused_insn;

  assign unused_insn = ^{insn_i[31:26], insn_i[24:0]};

  always_ff @(posedge clk) begin
    if (start_i) begin
      vd_cap   <= vd_old_i;
      sew_cap  <= sew_i;
      vl_cap   <= vl_i;
      mask_cap <= mask_i;
      all_cap  <= insn_i[25];
    end
  end

  always_comb begin
    tail_bm = '0;
    keep_bm = '0;
    for (int b = 0; b < NBYTES; b++) begin
      int el;
      el = b >> sew_cap;
      if (el >= int'(vl_cap)) begin
        tail_bm[b*8 +: 8] = 8'hFF;
      end else if (!all_cap && !mask_cap[el]) begin
        keep_bm[b*8 +: 8] = 8'hFF;
      end
    end
  end

  assert_valid_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> res_valid_o);

  assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !res_valid_o);

  assert_masked_lanes_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !illegal_o) |-> ((res_o & keep_bm) == (vd_cap & keep_bm)));

  assert_tail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !illegal_o) |-> ((res_o & tail_bm) == '0));

  assert_illegal_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && illegal_o) |-> (res_o == vd_cap));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(res_o) && $stable(illegal_o)));

endmodule

bind vmac_unit vmac_unit_chk #(
  .VLEN  (VLEN),
  .MAXEL (MAXEL),
  .VL_W  (VL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .insn_i      (insn_i),
  .vd_old_i    (vd_old_i),
  .sew_i       (sew_i),
  .vl_i        (vl_i),
  .mask_i      (mask_i),
  .res_valid_o (res_valid_o),
  .illegal_o   (illegal_o),
  .res_o       (res_o)
);

// File: tb/vmac_unit_test.sv
module vmac_unit_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [31:0]  insn_i;
  logic [127:0] vs2_i, vs1_i, vd_old_i;
  logic [63:0]  rs1_i;
  logic [1:0]   sew_i;
  logic [4:0]   vl_i;
  logic [15:0]  mask_i;
  logic         res_valid_o, illegal_o;
  logic [127:0] res_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  vmac_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
    .vs2_i(vs2_i), .vs1_i(vs1_i), .rs1_i(rs1_i), .vd_old_i(vd_old_i),
    .sew_i(sew_i), .vl_i(vl_i), .mask_i(mask_i),
    .res_valid_o(res_valid_o), .illegal_o(illegal_o), .res_o(res_o)
  );

  localparam logic [127:0] PA = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] PB = 128'h1111_2222_3333_4444_8000_7FFF_00FF_FF01;
  localparam logic [127:0] PD = 128'hA5A5_5A5A_0F0F_F0F0_CAFE_BABE_DEAD_BEEF;
  localparam logic [63:0]  SC = 64'hDEAD_BEEF_8765_4323;

  function automatic logic [31:0] mk(logic [5:0] f6, logic vm, logic [2:0] f3,
                                     logic [6:0] opc = 7'b1010111);
    return {f6, vm, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic bit is_legal(logic [31:0] insn);
    logic [5:0] f6;
    logic [2:0] f3;
    f6 = insn[31:26];
    f3 = insn[14:12];
    return (insn[6:0] == 7'b1010111) && (f3 == 3'b010 || f3 == 3'b110) &&
           (f6 == 6'b101101 || f6 == 6'b101111 || f6 == 6'b101001 || f6 == 6'b101011);
  endfunction

  // per-element model written from R2..R10
  function automatic logic [127:0] model(logic [31:0] insn, logic [127:0] a2,
      logic [127:0] a1, logic [63:0] sc, logic [127:0] d, logic [1:0] sew,
      logic [4:0] vl, logic [15:0] m);
    logic [127:0] r;
    int ew, nel;
    logic [63:0] msk, x2, x1, xd, v;
    if (!is_legal(insn)) return d;
    ew  = 8 << sew;
    nel = 128 / ew;
    msk = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
    r   = '0;
    for (int e = 0; e < nel; e++) begin
      x2 = (a2 >> (e * ew)) & msk;
      x1 = (insn[14:12] == 3'b110) ? (sc & msk) : ((a1 >> (e * ew)) & msk);
      xd = (d >> (e * ew)) & msk;
      if (e >= vl) v = 64'd0;
      else if (!insn[25] && !m[e]) v = xd;
      else begin
        case (insn[31:26])
          6'b101101: v = x1 * x2 + xd;
          6'b101111: v = xd - x1 * x2;
          6'b101001: v = x1 * xd + x2;
          default:   v = x2 - x1 * xd;
        endcase
        v = v & msk;
      end
      r = r | ({64'd0, v} << (e * ew));
    end
    return r;
  endfunction

  task automatic check(string req, string what, logic [127:0] got, logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // drive one operation, check result half a cycle after the capturing edge,
  // then check the valid pulse has ended and the result holds
  task automatic run_op(string req, logic [31:0] insn, logic [127:0] a2,
      logic [127:0] a1, logic [63:0] sc, logic [127:0] d, logic [1:0] sew,
      logic [4:0] vl, logic [15:0] m, output logic [127:0] got);
    logic [127:0] exp;
    exp = model(insn, a2, a1, sc, d, sew, vl, m);
    @(negedge clk);
    insn_i = insn; vs2_i = a2; vs1_i = a1; rs1_i = sc; vd_old_i = d;
    sew_i = sew; vl_i = vl; mask_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got = res_o;
    check("R1", "valid one cycle after start", {127'd0, res_valid_o}, 128'd1);
    check(req, "illegal flag", {127'd0, illegal_o}, {127'd0, !is_legal(insn)});
    check(req, "result", res_o, exp);
    @(negedge clk);
    check("R1", "valid is a single pulse", {127'd0, res_valid_o}, 128'd0);
  endtask

  task automatic t_reset();
    check("R1", "reset valid", {127'd0, res_valid_o}, 128'd0);
    check("R1", "reset illegal", {127'd0, illegal_o}, 128'd0);
    check("R1", "reset result", res_o, 128'd0);
  endtask

  task automatic t_ops();
    logic [127:0] g;
    run_op("R2", mk(6'b101101, 1'b1, 3'b010), PA, PB, SC, PD, 2'd0, 5'd16, 16'h0, g);
    run_op("R2", mk(6'b101101, 1'b1, 3'b010), PA, PB, SC, PD, 2'd3, 5'd16, 16'h0, g);
    run_op("R3", mk(6'b101111, 1'b1, 3'b010), PA, PB, SC, PD, 2'd1, 5'd16, 16'h0, g);
    run_op("R4", mk(6'b101001, 1'b1, 3'b010), PA, PB, SC, PD, 2'd2, 5'd16, 16'h0, g);
    run_op("R5", mk(6'b101011, 1'b1, 3'b010), PA, PB, SC, PD, 2'd3, 5'd16, 16'h0, g);
    run_op("R5", mk(6'b101011, 1'b1, 3'b010), PA, PB, SC, PD, 2'd0, 5'd16, 16'h0, g);
  endtask

  task automatic t_scalar();
    logic [127:0] g;
    run_op("R6", mk(6'b101101, 1'b1, 3'b110), PA, PB, SC, PD, 2'd0, 5'd16, 16'h0, g);
    run_op("R6", mk(6'b101001, 1'b1, 3'b110), PA, PB, SC, PD, 2'd2, 5'd16, 16'h0, g);
    // scalar low byte 0x02, vs2 bytes 0x03, vd bytes 0x01 -> 0x07 in every lane
    run_op("R6", mk(6'b101101, 1'b1, 3'b110), {16{8'h03}}, PB, 64'hFFFF_FF02,
           {16{8'h01}}, 2'd0, 5'd16, 16'h0, g);
    check("R6", "scalar truncated to 8 bits", g, {16{8'h07}});
  endtask

  task automatic t_wrap();
    logic [127:0] g;
    run_op("R7", mk(6'b101101, 1'b1, 3'b010), {16{8'h10}}, {16{8'h10}}, SC,
           {16{8'h01}}, 2'd0, 5'd16, 16'h0, g);
    check("R7", "8-bit product-sum wraps", g, {16{8'h01}});
    run_op("R7", mk(6'b101111, 1'b1, 3'b010), {8{16'h0001}}, {8{16'h0001}}, SC,
           128'd0, 2'd1, 5'd16, 16'h0, g);
    check("R7", "16-bit subtract wraps", g, {8{16'hFFFF}});
  endtask

  task automatic t_mask();
    logic [127:0] g;
    run_op("R8", mk(6'b101101, 1'b0, 3'b010), PA, PB, SC, PD, 2'd0, 5'd16, 16'hA5A5, g);
    run_op("R8", mk(6'b101011, 1'b0, 3'b010), PA, PB, SC, PD, 2'd1, 5'd16, 16'h00C3, g);
    // mask ignored when bit 25 is 1
    run_op("R8", mk(6'b101101, 1'b1, 3'b010), PA, PB, SC, PD, 2'd2, 5'd16, 16'h0000, g);
  endtask

  task automatic t_tail();
    logic [127:0] g;
    run_op("R9", mk(6'b101101, 1'b1, 3'b010), PA, PB, SC, PD, 2'd1, 5'd3, 16'h0, g);
    check("R9", "elements 3..7 zero", g & {{80{1'b1}}, 48'd0}, 128'd0);
    run_op("R9", mk(6'b101001, 1'b1, 3'b010), PA, PB, SC, PD, 2'd0, 5'd0, 16'h0, g);
    check("R9", "vl zero clears all", g, 128'd0);
    run_op("R9", mk(6'b101111, 1'b0, 3'b110), PA, PB, SC, PD, 2'd3, 5'd1, 16'h2, g);
  endtask

  task automatic t_illegal();
    logic [127:0] g;
    run_op("R10", mk(6'b101101, 1'b1, 3'b010, 7'b1010011), PA, PB, SC, PD, 2'd0, 5'd16, 16'h0, g);
    check("R10", "bad opcode keeps vd", g, PD);
    run_op("R10", mk(6'b101100, 1'b1, 3'b010), PA, PB, SC, PD, 2'd1, 5'd16, 16'h0, g);
    run_op("R10", mk(6'b101101, 1'b1, 3'b000), PA, PB, SC, PD, 2'd2, 5'd16, 16'h0, g);
  endtask

  task automatic t_hold();
    logic [127:0] g;
    run_op("R11", mk(6'b101101, 1'b1, 3'b010), PA, PB, SC, PD, 2'd0, 5'd16, 16'h0, g);
    @(negedge clk);
    insn_i = mk(6'b000000, 1'b1, 3'b000); vs2_i = PD; vs1_i = PA; vd_old_i = PB;
    repeat (3) @(negedge clk);
    check("R11", "result holds without start", res_o, g);
    check("R11", "illegal holds without start", {127'd0, illegal_o}, 128'd0);
    check("R1", "no valid without start", {127'd0, res_valid_o}, 128'd0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; insn_i = '0; vs2_i = '0; vs1_i = '0;
    rs1_i = '0; vd_old_i = '0; sew_i = '0; vl_i = '0; mask_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ops();
    t_scalar();
    t_wrap();
    t_mask();
    t_tail();
    t_illegal();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule